// File: doc/BRIEF.md
# NAND Program/Erase Operation Sequencer

This block is the device-side sequencer that runs the internal write operations of a small NAND flash. A command byte arrives with a one-cycle valid strobe. A page program is armed by the data-load command and launched by the program-go command. A block erase is armed by the erase-setup command and launched by the erase-go command. While an operation runs, the block holds its ready output low. It also presents an 8-bit status byte that can be read at any time.

The busy periods are plain cycle counts set by parameters. The pass/fail outcome of each operation is taken from a test input at the moment the operation completes. An erase can be suspended and later resumed. A resume restarts the erase period from its beginning. A reset command aborts whatever is running, holds the block busy for a fixed time and clears the status byte.

The controller has five states. IDLE waits for commands. PROG runs a page program. ERASE runs a block erase. SUSP holds a suspended erase. RESET holds the reset busy period. The transitions are:
- IDLE→PROG on program-go when a data-load is pending and protection is off.
- IDLE→ERASE on erase-go when an erase-setup is pending and protection is off.
- PROG/ERASE→IDLE when the busy counter expires.
- ERASE→SUSP on suspend.
- SUSP→ERASE on erase-go.
- Any state except RESET→RESET on the reset command.
- RESET→IDLE when the counter expires.

Top module: `nand_opseq`

## Requirements
- R1: After `rst_n` is released with `protect_n` high, `ready_o` is 1 and `status_o` reads 8'hC0.
- R2: Command 8'h80 followed later by 8'h10 makes `ready_o` 0 for exactly PROG_CYC cycles, starting the cycle after 8'h10 is taken.
- R3: Command 8'h10 starts nothing unless the last command in IDLE other than 8'h70 was 8'h80; `ready_o` stays 1.
- R4: Command 8'h60 followed later by 8'hD0 makes `ready_o` 0 for exactly ERASE_CYC cycles.
- R5: Status bit 0 takes the value of `fail_inject` at the cycle an operation completes: 0 means pass, 1 means error. It holds that value until the next completion or reset.
- R6: The status byte is laid out as follows. Bit 7 equals `protect_n`. Bit 6 equals the ready state (0 busy, 1 ready). Bit 5 is the suspend flag. Bits 4 to 1 always read 0. Bit 0 is the fail bit.
- R7: During a program or erase, every command other than 8'h70 and 8'hFF (and 8'hB0 during an erase) has no effect on the state or the busy length.
- R8: Command 8'hB0 during an erase sets `ready_o` to 1 and status bit 5 to 1 on the next cycle. While suspended, only 8'hD0, 8'h70 and 8'hFF act.
- R9: Command 8'hD0 while suspended clears bit 5 and restarts a full ERASE_CYC busy period.
- R10: Command 8'hFF aborts any operation or suspension, holds `ready_o` at 0 for RST_CYC cycles, and leaves the status at 8'hC0 (with `protect_n` high).
- R11: Command 8'hFF received while the reset period is running does not extend that period.
- R12: With `protect_n` low, commands 8'h10 and 8'hD0 start nothing and leave status bit 0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command byte strobe, one cycle per command |
| cmd_code | input | 8 | Command byte |
| protect_n | input | 1 | Write protect, active low |
| fail_inject | input | 1 | Outcome sampled at completion (1 = error) |
| ready_o | output | 1 | 1 when ready, 0 while busy |
| status_o | output | 8 | Status byte |

## Verification
The bench builds the block with PROG_CYC=12, ERASE_CYC=20 and RST_CYC=5. These short periods let each busy window be counted cycle by cycle. They are also long enough to fit six ignored commands inside one program period. Because the periods differ from one another, a program, an erase, a resumed erase and a reset period cannot be confused. The same short periods let the randomised program/erase mix with varying protection and injected outcomes run many complete operations.

// File: rtl/nand_opseq_pkg.sv
package nand_opseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_ERASE,
        ST_SUSP,
        ST_RESET
    } seq_state_t;

    localparam logic [7:0] OP_LOAD        = 8'h80;
    localparam logic [7:0] OP_PROG_GO     = 8'h10;
    localparam logic [7:0] OP_ERASE_SETUP = 8'h60;
    localparam logic [7:0] OP_ERASE_GO    = 8'hD0;
    localparam logic [7:0] OP_SUSPEND     = 8'hB0;
    localparam logic [7:0] OP_STATUS      = 8'h70;
    localparam logic [7:0] OP_RESET       = 8'hFF;

    function automatic logic [7:0] pack_status(input logic prot_n, input logic rdy,
                                               input logic susp, input logic fail);
        return {prot_n, rdy, susp, 4'b0000, fail};
    endfunction

endpackage

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic             done
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (run && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = run && (cnt == '0);

    // R11: a running period only ever steps down by one
    p_count_down_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/nand_status_reg.sv
module nand_status_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       cmpl,
    input  logic       fail_in,
    input  logic       susp_set,
    input  logic       susp_clr,
    input  logic       prot_n,
    input  logic       rdy,
    output logic [7:0] status_o
);
    import nand_opseq_pkg::*;

    logic fail_q;
    logic susp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fail_q <= 1'b0;
            susp_q <= 1'b0;
        end else if (clr) begin
            fail_q <= 1'b0;
            susp_q <= 1'b0;
        end else begin
            if (cmpl)
                fail_q <= fail_in;
            if (susp_set)
                susp_q <= 1'b1;
            else if (susp_clr)
                susp_q <= 1'b0;
        end
    end

    assign status_o = pack_status(prot_n, rdy, susp_q, fail_q);

    // R10: a reset entry leaves fail and suspend bits cleared
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (status_o[0] == 1'b0 && status_o[5] == 1'b0));

    // R5: the fail bit only moves on completion or clear
    p_fail_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmpl && !clr) |=> $stable(status_o[0]));

endmodule

// File: rtl/nand_opseq.sv
module nand_opseq #(
    parameter int PROG_CYC  = 40,
    parameter int ERASE_CYC = 120,
    parameter int RST_CYC   = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_code,
    input  logic       protect_n,
    input  logic       fail_inject,
    output logic       ready_o,
    output logic [7:0] status_o
);
    import nand_opseq_pkg::*;

    localparam int MAX_PE  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int MAX_CYC = (MAX_PE > RST_CYC) ? MAX_PE : RST_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] PROG_LD  = CNT_W'(PROG_CYC - 1);
    localparam logic [CNT_W-1:0] ERASE_LD = CNT_W'(ERASE_CYC - 1);
    localparam logic [CNT_W-1:0] RST_LD   = CNT_W'(RST_CYC - 1);

    seq_state_t state, nxt;
    logic prog_armed, erase_armed, pa_nxt, ea_nxt;
    logic ld, run, done, st_clr, cmpl, susp_set, susp_clr;
    logic [CNT_W-1:0] ld_val, tmr_cnt;
    logic is_rst;

    assign is_rst = cmd_valid && (cmd_code == OP_RESET);
    assign run    = (state == ST_PROG) || (state == ST_ERASE) || (state == ST_RESET);

    nand_busy_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val),
        .run(run), .cnt(tmr_cnt), .done(done)
    );

    nand_status_reg u_status (
        .clk(clk), .rst_n(rst_n), .clr(st_clr), .cmpl(cmpl), .fail_in(fail_inject),
        .susp_set(susp_set), .susp_clr(susp_clr), .prot_n(protect_n),
        .rdy(ready_o), .status_o(status_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            prog_armed  <= 1'b0;
            erase_armed <= 1'b0;
        end else begin
            state       <= nxt;
            prog_armed  <= pa_nxt;
            erase_armed <= ea_nxt;
        end
    end

    always_comb begin
        nxt      = state;
        pa_nxt   = prog_armed;
        ea_nxt   = erase_armed;
        ld       = 1'b0;
        ld_val   = '0;
        st_clr   = 1'b0;
        cmpl     = 1'b0;
        susp_set = 1'b0;
        susp_clr = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    case (cmd_code)
                        OP_LOAD: begin
                            pa_nxt = 1'b1;
                            ea_nxt = 1'b0;
                        end
                        OP_ERASE_SETUP: begin
                            pa_nxt = 1'b0;
                            ea_nxt = 1'b1;
                        end
                        OP_PROG_GO: begin
                            pa_nxt = 1'b0;
                            ea_nxt = 1'b0;
                            if (prog_armed && protect_n) begin
                                nxt    = ST_PROG;
                                ld     = 1'b1;
                                ld_val = PROG_LD;
                            end
                        end
                        OP_ERASE_GO: begin
                            pa_nxt = 1'b0;
                            ea_nxt = 1'b0;
                            if (erase_armed && protect_n) begin
                                nxt    = ST_ERASE;
                                ld     = 1'b1;
                                ld_val = ERASE_LD;
                            end
                        end
                        OP_STATUS: begin
                        end
                        OP_RESET: begin
                            pa_nxt = 1'b0;
                            ea_nxt = 1'b0;
                            nxt    = ST_RESET;
                            ld     = 1'b1;
                            ld_val = RST_LD;
                            st_clr = 1'b1;
                        end
                        default: begin
                            pa_nxt = 1'b0;
                            ea_nxt = 1'b0;
                        end
                    endcase
                end
            end
            ST_PROG, ST_ERASE, ST_SUSP: begin
                if (is_rst) begin
                    nxt    = ST_RESET;
                    ld     = 1'b1;
                    ld_val = RST_LD;
                    st_clr = 1'b1;
                end else if (state != ST_SUSP && done) begin
                    nxt  = ST_IDLE;
                    cmpl = 1'b1;
                end else if (state == ST_ERASE && cmd_valid && cmd_code == OP_SUSPEND) begin
                    nxt      = ST_SUSP;
                    susp_set = 1'b1;
                end else if (state == ST_SUSP && cmd_valid && cmd_code == OP_ERASE_GO) begin
                    nxt      = ST_ERASE;
                    ld       = 1'b1;
                    ld_val   = ERASE_LD;
                    susp_clr = 1'b1;
                end
            end
            ST_RESET: begin
                if (done)
                    nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        ready_o = (state == ST_IDLE) || (state == ST_SUSP);
    end

    // R7: a program keeps running through any non-reset command
    p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG && !done && !is_rst) |=> (state == ST_PROG));

    // R3: program-go without a pending load stays idle
    p_no_unarmed_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cmd_valid && cmd_code == OP_PROG_GO && !prog_armed)
        |=> (state == ST_IDLE));

    // R12: with protection on nothing but reset leaves idle
    p_protect_reject_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cmd_valid && !protect_n && cmd_code != OP_RESET)
        |=> (state == ST_IDLE && ready_o));

    // R8: suspend makes the block ready and flags the suspension
    p_suspend_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASE && !done && cmd_valid && cmd_code == OP_SUSPEND)
        |=> (ready_o && status_o[5]));

    // R9: resume reloads the full erase period
    p_resume_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUSP && !is_rst && cmd_valid && cmd_code == OP_ERASE_GO)
        |=> (!ready_o && !status_o[5] && tmr_cnt == ERASE_LD));

endmodule

// File: tb/nand_opseq_bench.sv
module nand_opseq_bench;

    localparam int PC = 12;
    localparam int EC = 20;
    localparam int RC = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_code = 8'h00;
    logic       protect_n = 1'b1;
    logic       fail_inject = 1'b0;
    wire        ready_o;
    wire  [7:0] status_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    nand_opseq #(.PROG_CYC(PC), .ERASE_CYC(EC), .RST_CYC(RC)) u_nand_opseq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .protect_n(protect_n), .fail_inject(fail_inject),
        .ready_o(ready_o), .status_o(status_o)
    );

    function automatic logic [7:0] exp_st(input logic p, input logic r,
                                          input logic s, input logic f);
        return {p, r, s, 4'b0000, f};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [7:0] c);
        cmd_code  = c;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (!ready_o && n < 10000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int n;
        int m;
        logic exp_fail;
        logic [7:0] ign [6] = '{8'h60, 8'hD0, 8'hB0, 8'h80, 8'h00, 8'h10};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after reset", ready_o, 1);
        check("R1 status after reset", status_o, 8'hC0);

        protect_n = 1'b0;
        @(negedge clk);
        check("R6 protect bit", status_o, 8'h40);
        protect_n = 1'b1;

        // R3: unarmed program-go
        issue(8'h10);
        check("R3 lone 10h", ready_o, 1);
        issue(8'h80); issue(8'h00); issue(8'h10);
        check("R3 arm cleared", ready_o, 1);

        // R2 / R5 / R6: program pass
        fail_inject = 1'b0;
        issue(8'h80); issue(8'h10);
        check("R6 busy status", status_o, exp_st(1, 0, 0, 0));
        busy_len(n);
        check("R2 program length", n, PC);
        check("R5 pass status", status_o, 8'hC0);

        // R5: program fail
        fail_inject = 1'b1;
        issue(8'h80); issue(8'h70); issue(8'h10);
        busy_len(n);
        check("R2 program length 70h between", n, PC);
        check("R5 fail status", status_o, 8'hC1);
        fail_inject = 1'b0;

        // R4: erase
        issue(8'h60); issue(8'hD0);
        busy_len(n);
        check("R4 erase length", n, EC);
        check("R5 erase pass", status_o, 8'hC0);

        // R7: ignored commands during program
        issue(8'h80); issue(8'h10);
        n = 0;
        foreach (ign[i]) begin
            if (!ready_o) n++;
            issue(ign[i]);
        end
        busy_len(m);
        check("R7 program length unchanged", n + m, PC);

        // R8 / R9: suspend and resume
        issue(8'h60); issue(8'hD0);
        issue(8'h70); issue(8'h70);
        issue(8'hB0);
        check("R8 ready on suspend", ready_o, 1);
        check("R8 suspend status", status_o, 8'hE0);
        issue(8'h80); issue(8'h10); issue(8'h60);
        check("R8 suspended stays ready", ready_o, 1);
        check("R8 suspended status", status_o, 8'hE0);
        issue(8'hD0);
        check("R9 resume status", status_o, 8'h80);
        busy_len(n);
        check("R9 resume full length", n, EC);
        check("R9 after resume", status_o, 8'hC0);

        // R10: abort program with earlier fail set
        fail_inject = 1'b1;
        issue(8'h80); issue(8'h10);
        busy_len(n);
        fail_inject = 1'b0;
        check("R5 fail before abort", status_o, 8'hC1);
        issue(8'h80); issue(8'h10); issue(8'h70);
        issue(8'hFF);
        busy_len(n);
        check("R10 reset length", n, RC);
        check("R10 status cleared", status_o, 8'hC0);

        // R10: abort a suspension
        issue(8'h60); issue(8'hD0); issue(8'hB0);
        issue(8'hFF);
        busy_len(n);
        check("R10 reset from suspend length", n, RC);
        check("R10 suspend cleared", status_o, 8'hC0);

        // R11: reset during reset
        issue(8'hFF);
        n = 0;
        if (!ready_o) n++;
        issue(8'hFF);
        busy_len(m);
        check("R11 reset not extended", n + m, RC);

        // R12: protection blocks confirms, fail bit kept
        fail_inject = 1'b1;
        issue(8'h80); issue(8'h10);
        busy_len(n);
        check("R5 fail set", status_o, 8'hC1);
        protect_n   = 1'b0;
        fail_inject = 1'b0;
        issue(8'h80); issue(8'h10);
        check("R12 program blocked", ready_o, 1);
        issue(8'h60); issue(8'hD0);
        @(negedge clk);
        check("R12 erase blocked", ready_o, 1);
        check("R12 fail bit kept", status_o, 8'h41);
        protect_n = 1'b1;
        exp_fail  = 1'b1;

        // random mix
        void'($urandom(32'h5eed_1234));
        for (int it = 0; it < 40; it++) begin
            logic op;
            logic fi;
            logic wp;
            op = 1'($urandom % 2);
            fi = 1'($urandom % 2);
            wp = (($urandom % 4) != 0);
            protect_n   = wp;
            fail_inject = fi;
            if (op) begin
                issue(8'h80); issue(8'h10);
            end else begin
                issue(8'h60); issue(8'hD0);
            end
            busy_len(n);
            if (wp) begin
                exp_fail = fi;
                check(op ? "R2 random program length" : "R4 random erase length",
                      n, op ? PC : EC);
            end else begin
                check("R12 random blocked", n, 0);
            end
            check("R5 random status", status_o, exp_st(wp, 1, 0, exp_fail));
        end

        finish_run();
    end

endmodule